// File: doc/BRIEF.md
# Hashed inverted page table walker

This block translates a process's virtual page into a physical frame number. It uses a table with exactly one entry per physical frame, and it returns the index of the matching entry as the frame number. Each entry records the process that owns the frame, the virtual page mapped into it, three permission bits (read, write, execute), a live bit and a link to the next entry in the same hash bucket. One table is shared by every process, so a lookup matches only when both the process ID and the page number agree.

A lookup folds the page number down to a starting frame index and reads that entry. If the entry is not the owner, the walker follows the link chain one entry per clock until one of four things happens: it finds the owner, it reaches a dead entry, it reaches a null link, or it has examined as many entries as there are frames. The result comes back on a valid/ready response channel together with a status code. Software fills entries through a write port, which accepts writes only while no lookup is in flight.

Top module: `ipt_walker`

## Requirements
- R1: After reset, req_ready_o and wr_ready_o are 1, resp_valid_o is 0, and every entry is dead, so any lookup returns the fault status.
- R2: The starting frame index is the XOR of the page number's IDX_W-bit slices (for the default 12-bit page and 4-bit index: vpn[3:0]^vpn[7:4]^vpn[11:8]). A lookup that matches at its starting entry responds after 1 walk cycle.
- R3: A match requires the entry to be live and both its process ID and its page number to equal the request's. A mismatch in either field does not match.
- R4: On a mismatch, the walker moves to the entry named by the link, examining one entry per clock. resp_valid_o rises at the L-th rising edge after acceptance, where L is the number of entries examined, and resp_frame_o is the index of the matching entry.
- R5: Reaching a dead entry, or a non-matching entry whose link has its MSB (bit IDX_W) set, ends the walk with status 1 (fault). resp_frame_o and resp_prot_o are then 0.
- R6: Access codes are 0 read, 1 write, 2 execute and 3 reserved. Protection bits are bit0 R, bit1 W and bit2 X. A match whose bit for the access is clear, or any match with code 3, returns status 2 (protection), together with the entry's frame and protection bits. Otherwise the status is 0 (hit).
- R7: If NFRAMES entries have been examined without reaching an end, the walker reports status 3 (chain loop) at the NFRAMES-th edge, with frame and protection bits 0.
- R8: Only one lookup is in flight at a time. req_ready_o stays low from acceptance until the response is taken, and the response holds stable while resp_ready_i is low.
- R9: Writes take effect only when wr_ready_o is 1, which holds only while the walker is idle. A write offered during a walk leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_pid_i | input | PID_W | Requesting process ID |
| req_vpn_i | input | VPN_W | Virtual page number |
| req_acc_i | input | 2 | Access code (0 R, 1 W, 2 X, 3 reserved) |
| resp_valid_o | output | 1 | Response valid |
| resp_ready_i | input | 1 | Response taken |
| resp_status_o | output | 2 | 0 hit, 1 fault, 2 protection, 3 chain loop |
| resp_frame_o | output | IDX_W | Matching frame index |
| resp_prot_o | output | 3 | Protection bits of the matching entry |
| wr_valid_i | input | 1 | Entry write request |
| wr_ready_o | output | 1 | Write accepted (walker idle) |
| wr_frame_i | input | IDX_W | Entry index to write |
| wr_pid_i | input | PID_W | Owner process ID |
| wr_vpn_i | input | VPN_W | Mapped page number |
| wr_prot_i | input | 3 | Protection bits |
| wr_live_i | input | 1 | Entry live bit |
| wr_next_i | input | IDX_W+1 | Chain link; MSB set means null |

## Verification
The assertions assume the requester holds the access code stable only during the acceptance cycle. They also assume the consumer may stall the response for any number of cycles. Neither is a constraint on the design, because the checker captures the access code when the request is accepted. The stimulus offers requests only while req_ready_o is high. It stalls the response for several cycles in one directed case. It deliberately offers a write while a walk is running, so the ignore path is exercised rather than assumed. The chain-loop case builds a two-entry cycle on purpose, and this keeps the walk-length bound exercised at its limit.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  typedef enum logic [1:0] {
    ST_HIT   = 2'd0,
    ST_FAULT = 2'd1,
    ST_PROT  = 2'd2,
    ST_LOOP  = 2'd3
  } ipt_status_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } ipt_acc_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WALK = 2'd1,
    S_RESP = 2'd2
  } walk_state_e;

endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int VPN_W = 12,
  parameter int IDX_W = 4
) (
  input  logic [VPN_W-1:0] vpn_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int SLICES = (VPN_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = SLICES * IDX_W;

  logic [PAD_W-1:0] pad;
  assign pad = PAD_W'(vpn_i);

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < SLICES; i++) begin
      idx_o = idx_o ^ pad[i*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int IDX_W = 4,
  parameter int PID_W = 4,
  parameter int VPN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [PID_W-1:0] wpid_i,
  input  logic [VPN_W-1:0] wvpn_i,
  input  logic [2:0]       wprot_i,
  input  logic             wlive_i,
  input  logic [IDX_W:0]   wnext_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic             rlive_o,
  output logic [PID_W-1:0] rpid_o,
  output logic [VPN_W-1:0] rvpn_o,
  output logic [2:0]       rprot_o,
  output logic [IDX_W:0]   rnext_o
);
  localparam int NFRAMES = 1 << IDX_W;

  logic [NFRAMES-1:0] live_q;
  logic [PID_W-1:0]   pid_q  [NFRAMES];
  logic [VPN_W-1:0]   vpn_q  [NFRAMES];
  logic [2:0]         prot_q [NFRAMES];
  logic [IDX_W:0]     next_q [NFRAMES];

  // only the live bits need reset; dead entries never match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   live_q <= '0;
    else if (we_i) live_q[widx_i] <= wlive_i;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      pid_q[widx_i]  <= wpid_i;
      vpn_q[widx_i]  <= wvpn_i;
      prot_q[widx_i] <= wprot_i;
      next_q[widx_i] <= wnext_i;
    end
  end

  assign rlive_o = live_q[ridx_i];
  assign rpid_o  = pid_q[ridx_i];
  assign rvpn_o  = vpn_q[ridx_i];
  assign rprot_o = prot_q[ridx_i];
  assign rnext_o = next_q[ridx_i];
endmodule

// File: rtl/ipt_walk_fsm.sv
module ipt_walk_fsm
  import ipt_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int PID_W = 4,
  parameter int VPN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [PID_W-1:0] req_pid_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [1:0]       req_acc_i,
  input  logic [IDX_W-1:0] home_idx_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic             ent_live_i,
  input  logic [PID_W-1:0] ent_pid_i,
  input  logic [VPN_W-1:0] ent_vpn_i,
  input  logic [2:0]       ent_prot_i,
  input  logic [IDX_W:0]   ent_next_i,
  output logic             resp_valid_o,
  input  logic             resp_ready_i,
  output logic [1:0]       resp_status_o,
  output logic [IDX_W-1:0] resp_frame_o,
  output logic [2:0]       resp_prot_o
);
  walk_state_e      state_q;
  logic [IDX_W-1:0] cur_q, step_q, frame_q;
  logic [PID_W-1:0] pid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [1:0]       acc_q;
  ipt_status_e      status_q;
  logic [2:0]       prot_q;

  logic       owner, chain_end, last_step, perm_ok;
  logic [3:0] prot_ext;

  always_comb begin
    owner     = ent_live_i && (ent_pid_i == pid_q) && (ent_vpn_i == vpn_q);
    chain_end = !ent_live_i || ent_next_i[IDX_W];
    last_step = (step_q == {IDX_W{1'b1}});
    prot_ext  = {1'b0, ent_prot_i};   // reserved code hits the zero bit
    perm_ok   = prot_ext[acc_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cur_q    <= '0;
      step_q   <= '0;
      pid_q    <= '0;
      vpn_q    <= '0;
      acc_q    <= '0;
      status_q <= ST_HIT;
      frame_q  <= '0;
      prot_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          pid_q   <= req_pid_i;
          vpn_q   <= req_vpn_i;
          acc_q   <= req_acc_i;
          cur_q   <= home_idx_i;
          step_q  <= '0;
          state_q <= S_WALK;
        end
        S_WALK: begin
          if (owner) begin
            status_q <= perm_ok ? ST_HIT : ST_PROT;
            frame_q  <= cur_q;
            prot_q   <= ent_prot_i;
            state_q  <= S_RESP;
          end else if (chain_end) begin
            status_q <= ST_FAULT;
            frame_q  <= '0;
            prot_q   <= '0;
            state_q  <= S_RESP;
          end else if (last_step) begin
            status_q <= ST_LOOP;
            frame_q  <= '0;
            prot_q   <= '0;
            state_q  <= S_RESP;
          end else begin
            cur_q  <= ent_next_i[IDX_W-1:0];
            step_q <= step_q + 1'b1;
          end
        end
        S_RESP: if (resp_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == S_IDLE);
  assign rd_idx_o      = cur_q;
  assign resp_valid_o  = (state_q == S_RESP);
  assign resp_status_o = status_q;
  assign resp_frame_o  = frame_q;
  assign resp_prot_o   = prot_q;
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker #(
  parameter int IDX_W = 4,
  parameter int PID_W = 4,
  parameter int VPN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [PID_W-1:0] req_pid_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [1:0]       req_acc_i,
  output logic             resp_valid_o,
  input  logic             resp_ready_i,
  output logic [1:0]       resp_status_o,
  output logic [IDX_W-1:0] resp_frame_o,
  output logic [2:0]       resp_prot_o,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [IDX_W-1:0] wr_frame_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [2:0]       wr_prot_i,
  input  logic             wr_live_i,
  input  logic [IDX_W:0]   wr_next_i
);
  logic [IDX_W-1:0] home_idx, rd_idx;
  logic             ent_live;
  logic [PID_W-1:0] ent_pid;
  logic [VPN_W-1:0] ent_vpn;
  logic [2:0]       ent_prot;
  logic [IDX_W:0]   ent_next;
  logic             idle;

  ipt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
    .vpn_i(req_vpn_i),
    .idx_o(home_idx)
  );

  ipt_table #(.IDX_W(IDX_W), .PID_W(PID_W), .VPN_W(VPN_W)) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_valid_i && idle),
    .widx_i (wr_frame_i),
    .wpid_i (wr_pid_i),
    .wvpn_i (wr_vpn_i),
    .wprot_i(wr_prot_i),
    .wlive_i(wr_live_i),
    .wnext_i(wr_next_i),
    .ridx_i (rd_idx),
    .rlive_o(ent_live),
    .rpid_o (ent_pid),
    .rvpn_o (ent_vpn),
    .rprot_o(ent_prot),
    .rnext_o(ent_next)
  );

  ipt_walk_fsm #(.IDX_W(IDX_W), .PID_W(PID_W), .VPN_W(VPN_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (idle),
    .req_pid_i    (req_pid_i),
    .req_vpn_i    (req_vpn_i),
    .req_acc_i    (req_acc_i),
    .home_idx_i   (home_idx),
    .rd_idx_o     (rd_idx),
    .ent_live_i   (ent_live),
    .ent_pid_i    (ent_pid),
    .ent_vpn_i    (ent_vpn),
    .ent_prot_i   (ent_prot),
    .ent_next_i   (ent_next),
    .resp_valid_o (resp_valid_o),
    .resp_ready_i (resp_ready_i),
    .resp_status_o(resp_status_o),
    .resp_frame_o (resp_frame_o),
    .resp_prot_o  (resp_prot_o)
  );

  assign req_ready_o = idle;
  assign wr_ready_o  = idle;
endmodule

// File: rtl/ipt_walker_chk.sv
module ipt_walker_chk #(
  parameter int IDX_W = 4,
  parameter int PID_W = 4,
  parameter int VPN_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [1:0]       req_acc_i,
  input logic             resp_valid_o,
  input logic             resp_ready_i,
  input logic [1:0]       resp_status_o,
  input logic [IDX_W-1:0] resp_frame_o,
  input logic [2:0]       resp_prot_o,
  input logic             wr_ready_o
);
  localparam int NFRAMES = 1 << IDX_W;
  localparam int CNT_W   = IDX_W + 2;

  logic [1:0]       acc_q;
  logic [CNT_W-1:0] walk_cnt;
  logic [3:0]       prot_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      walk_cnt <= '0;
    end else if (req_valid_i && req_ready_o) begin
      acc_q    <= req_acc_i;
      walk_cnt <= CNT_W'(1);
    end else if (resp_valid_o) begin
      walk_cnt <= '0;
    end else if (walk_cnt != '0) begin
      walk_cnt <= walk_cnt + 1'b1;
    end
  end

  assign prot_ext = {1'b0, resp_prot_o};

  p_resp_blocks_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !req_ready_o);

  p_accept_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && !resp_valid_o));

  p_no_write_in_walk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !wr_ready_o);

  p_resp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_ready_i) |=> (resp_valid_o && $stable(resp_status_o)
      && $stable(resp_frame_o) && $stable(resp_prot_o)));

  p_fault_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_status_o == 2'd1) |-> (resp_frame_o == '0 && resp_prot_o == '0));

  p_loop_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_status_o == 2'd3) |-> (resp_frame_o == '0 && resp_prot_o == '0));

  p_hit_perm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_status_o == 2'd0) |-> prot_ext[acc_q]);

  p_walk_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_cnt <= CNT_W'(NFRAMES + 1));
endmodule

bind ipt_walker ipt_walker_chk #(.IDX_W(IDX_W), .PID_W(PID_W), .VPN_W(VPN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_acc_i    (req_acc_i),
  .resp_valid_o (resp_valid_o),
  .resp_ready_i (resp_ready_i),
  .resp_status_o(resp_status_o),
  .resp_frame_o (resp_frame_o),
  .resp_prot_o  (resp_prot_o),
  .wr_ready_o   (wr_ready_o)
);

// File: tb/sim_ipt_walker.sv
module sim_ipt_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] NUL = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, resp_ready = 1'b0, wr_valid = 1'b0, wr_live = 1'b0;
  logic [3:0]  req_pid = '0, wr_frame = '0, wr_pid = '0;
  logic [11:0] req_vpn = '0, wr_vpn = '0;
  logic [1:0]  req_acc = '0;
  logic [2:0]  wr_prot = '0;
  logic [4:0]  wr_next = '0;
  logic        req_ready, resp_valid, wr_ready;
  logic [1:0]  resp_status;
  logic [3:0]  resp_frame;
  logic [2:0]  resp_prot;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipt_walker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_pid_i(req_pid), .req_vpn_i(req_vpn), .req_acc_i(req_acc),
    .resp_valid_o(resp_valid), .resp_ready_i(resp_ready),
    .resp_status_o(resp_status), .resp_frame_o(resp_frame), .resp_prot_o(resp_prot),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_frame_i(wr_frame),
    .wr_pid_i(wr_pid), .wr_vpn_i(wr_vpn), .wr_prot_i(wr_prot),
    .wr_live_i(wr_live), .wr_next_i(wr_next)
  );

  typedef struct packed {
    logic [7:0]  tag;
    logic [3:0]  pid;
    logic [11:0] vpn;
    logic [1:0]  acc;
    logic [1:0]  st;
    logic [3:0]  frame;
    logic [2:0]  prot;
    logic [4:0]  lat;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VEC [NVEC] = '{
    '{8'd2, 4'd1, 12'h003, 2'd0, 2'd0, 4'd3,  3'b011, 5'd1},  // R2 home hit
    '{8'd6, 4'd1, 12'h003, 2'd1, 2'd0, 4'd3,  3'b011, 5'd1},  // R6 write allowed
    '{8'd6, 4'd1, 12'h003, 2'd2, 2'd2, 4'd3,  3'b011, 5'd1},  // R6 exec denied
    '{8'd4, 4'd2, 12'h050, 2'd0, 2'd0, 4'd9,  3'b001, 5'd2},  // R4 second link
    '{8'd4, 4'd3, 12'h500, 2'd2, 2'd0, 4'd12, 3'b111, 5'd3},  // R4 third link
    '{8'd3, 4'd2, 12'h500, 2'd0, 2'd1, 4'd0,  3'b000, 5'd3},  // R3 pid mismatch, R5 null end
    '{8'd6, 4'd2, 12'h005, 2'd1, 2'd2, 4'd5,  3'b101, 5'd1},  // R6 write denied
    '{8'd6, 4'd2, 12'h005, 2'd2, 2'd0, 4'd5,  3'b101, 5'd1},  // R6 exec allowed
    '{8'd6, 4'd2, 12'h050, 2'd3, 2'd2, 4'd9,  3'b001, 5'd2},  // R6 reserved code
    '{8'd3, 4'd3, 12'h003, 2'd0, 2'd1, 4'd0,  3'b000, 5'd1},  // R3 wrong pid
    '{8'd3, 4'd1, 12'h030, 2'd0, 2'd1, 4'd0,  3'b000, 5'd1},  // R3 wrong vpn
    '{8'd5, 4'd4, 12'h070, 2'd0, 2'd1, 4'd0,  3'b000, 5'd2},  // R5 dead entry in chain
    '{8'd2, 4'd6, 12'hABC, 2'd1, 2'd0, 4'd13, 3'b111, 5'd1},  // R2 fold of all slices
    '{8'd5, 4'd2, 12'h0A0, 2'd0, 2'd1, 4'd0,  3'b000, 5'd1},  // R5 dead home entry
    '{8'd7, 4'd5, 12'h0E0, 2'd0, 2'd3, 4'd0,  3'b000, 5'd16}  // R7 chain loop
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [3:0] pid, input logic [11:0] vpn,
                    input logic [2:0] prot, input logic live, input logic [4:0] nxt);
    @(negedge clk);
    wr_frame = idx; wr_pid = pid; wr_vpn = vpn; wr_prot = prot;
    wr_live = live; wr_next = nxt; wr_valid = 1'b1;
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic start_req(input logic [3:0] pid, input logic [11:0] vpn, input logic [1:0] acc);
    @(negedge clk);
    req_pid = pid; req_vpn = vpn; req_acc = acc; req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_resp(output int lat);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!resp_valid && lat < 40);
  endtask

  task automatic take_resp();
    @(negedge clk);
    resp_ready = 1'b1;
    @(posedge clk);
    #1 resp_ready = 1'b0;
  endtask

  task automatic lookup(input logic [3:0] pid, input logic [11:0] vpn, input logic [1:0] acc,
                        output int st, output int fr, output int pr, output int lat);
    start_req(pid, vpn, acc);
    wait_resp(lat);
    st = resp_status; fr = resp_frame; pr = resp_prot;
    take_resp();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int st, fr, pr, lat;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 resp_valid", resp_valid, 0);
    lookup(4'd1, 12'h003, 2'd0, st, fr, pr, lat);
    chk("R1 empty table status", st, 1);

    wr(4'd3,  4'd1, 12'h003, 3'b011, 1'b1, NUL);
    wr(4'd5,  4'd2, 12'h005, 3'b101, 1'b1, 5'd9);
    wr(4'd9,  4'd2, 12'h050, 3'b001, 1'b1, 5'd12);
    wr(4'd12, 4'd3, 12'h500, 3'b111, 1'b1, NUL);
    wr(4'd7,  4'd4, 12'h007, 3'b001, 1'b1, 5'd10);
    wr(4'd13, 4'd6, 12'hABC, 3'b111, 1'b1, NUL);
    wr(4'd14, 4'd5, 12'h00E, 3'b001, 1'b1, 5'd15);
    wr(4'd15, 4'd5, 12'h00F, 3'b001, 1'b1, 5'd14);

    for (int i = 0; i < NVEC; i++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VEC[i].tag, i);
      chk({t, " ready"}, req_ready, 1);
      lookup(VEC[i].pid, VEC[i].vpn, VEC[i].acc, st, fr, pr, lat);
      chk({t, " status"}, st, int'(VEC[i].st));
      chk({t, " frame"}, fr, int'(VEC[i].frame));
      chk({t, " prot"}, pr, int'(VEC[i].prot));
      chk({t, " latency"}, lat, int'(VEC[i].lat));
    end

    // R8 response held under stall, request blocked
    start_req(4'd2, 12'h050, 2'd0);
    wait_resp(lat);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 held valid", resp_valid, 1);
      chk("R8 held frame", resp_frame, 9);
      chk("R8 req blocked", req_ready, 0);
    end
    take_resp();
    @(negedge clk);
    chk("R8 released valid", resp_valid, 0);
    chk("R8 ready again", req_ready, 1);

    // R9 write offered during a long walk is dropped
    start_req(4'd5, 12'h0E0, 2'd0);
    @(negedge clk);
    wr_frame = 4'd10; wr_pid = 4'd7; wr_vpn = 12'h0A0; wr_prot = 3'b111;
    wr_live = 1'b1; wr_next = NUL; wr_valid = 1'b1;
    chk("R9 wr_ready busy", wr_ready, 0);
    repeat (2) @(posedge clk);
    #1 wr_valid = 1'b0;
    wait_resp(lat);
    chk("R7 loop status", resp_status, 3);
    take_resp();
    lookup(4'd7, 12'h0A0, 2'd0, st, fr, pr, lat);
    chk("R9 busy write ignored", st, 1);
    wr(4'd10, 4'd7, 12'h0A0, 3'b111, 1'b1, NUL);
    lookup(4'd7, 12'h0A0, 2'd0, st, fr, pr, lat);
    chk("R9 idle write status", st, 0);
    chk("R9 idle write frame", fr, 10);

    // R1 reset clears live bits
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    lookup(4'd1, 12'h003, 2'd0, st, fr, pr, lat);
    chk("R1 cleared status", st, 1);
    chk("R1 cleared frame", fr, 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule